// File: doc/BRIEF.md
# PTP Receive Timestamp Filter

This block watches the receive path of an Ethernet port and decides, frame by frame, whether the frame is a precision-time event message whose arrival time must be kept. It does not parse frames itself. An upstream parser supplies a start-of-frame pulse and, a few cycles later, one header strobe that carries the decoded fields: EtherType, a UDP flag, the UDP destination port, the PTP version, the v1 control byte and the v2 message type.

The system time is sampled into a snapshot register a fixed number of cycles after the start-of-frame pulse. That delay is the parameter `SOF_LAT`. When the header strobe arrives and the frame passes the selected filter, the snapshot moves into a 64-bit timestamp latch and a valid flag is raised. The latch keeps that value until software reads the upper half.

Software uses five word addresses. Three of them configure the filter: control, match and UDP port. The other two read the lower and upper halves of the timestamp.

Top module: `ptp_rx_stamp`

## Requirements
- R1: After reset the control word reads as zero, except bit 5, which always shows the `FREQ_IND` parameter. The match and port words read zero, and `ts_valid` is low.
- R2: A write to address 0 sets the enable from bit 4 and the filter mode from bits 3:1. Bits 0 and 5 are not writable. Address 1 holds the EtherType in bits 15:0, the v1 control selector in bits 23:16 and the v2 message selector in bits 31:24. Address 2 holds the port in bits 15:0. All three read back what was written.
- R3: On a capture, the latched time equals the `sys_time` input seen at the clock edge `SOF_LAT` cycles after the edge that samples `sof`. It reads at address 3 (bits 31:0) and address 4 (bits 63:32).
- R4: Mode field 0 (control 0x00) captures only non-UDP frames whose EtherType equals the match EtherType and whose version is 2. The message type, zero-extended to 8 bits, must equal the v2 selector, or be 2 or 3 (peer-delay request and response).
- R5: Mode field 1 (control 0x02) captures only UDP frames at the selected port with version 1 whose control byte equals the v1 selector. The port register holds the port with its two bytes swapped, so 0x3F01 selects port 319. A port register of zero matches no UDP frame.
- R6: Mode field 2 (control 0x04) applies the version-2 message test of R4 to frames that hit either the EtherType test of R4 or the port test of R5.
- R7: Mode field 4 (control 0x08) captures every frame, whatever its header holds.
- R8: Mode field 5 (control 0x0A) captures version-2 frames with a message type from 0 to 3 that hit either the EtherType test or the port test.
- R9: Mode fields 3, 6 and 7 capture no frame.
- R10: With the enable bit clear, no frame is captured, whatever the mode field holds.
- R11: While the valid flag is set, later matching frames leave the latched time unchanged.
- R12: A read of address 4 clears the valid flag (control bit 0). A read of address 3 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_time | input | TIME_W | Free-running system time |
| sof | input | 1 | Start-of-frame pulse |
| hdr_valid | input | 1 | One-cycle strobe: the header fields are valid |
| hdr_etype | input | 16 | Frame EtherType |
| hdr_is_udp | input | 1 | Frame carries UDP |
| hdr_udp_dport | input | 16 | UDP destination port, natural value |
| hdr_ptp_ver | input | 4 | PTP version |
| hdr_v1_ctrl | input | 8 | Version-1 control byte |
| hdr_v2_msg | input | 4 | Version-2 message type |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ts_valid | output | 1 | A timestamp is held |

## Verification
The bench attacks the places where the selectors interact.

- **Port byte order.** A design that compared the port without the byte swap would miss real port-319 frames and would accept port 0x3F01.
- **Peer-delay messages in the v2 modes.** Dropping the extra peer-delay types would lose message types 2 and 3.
- **Zero port register.** A design that did not treat a zero port specially would match UDP frames sent to port 0.
- **Holding the latch.** A latch that did not hold would report the second frame's time, not the first.
- **Low-half read.** A low-half read that also cleared the flag would let a later frame overwrite a stamp that was only half read.
- **Sampling time.** Each capture is compared to the exact time `SOF_LAT` cycles after the start pulse, so an off-by-one pipeline shows up as an error of one time increment.

// File: rtl/ptp_rx_stamp_pkg.sv
package ptp_rx_stamp_pkg;

   localparam int REG_W   = 32;
   localparam int ADDR_W  = 3;
   localparam int ETYPE_W = 16;
   localparam int PORT_W  = 16;
   localparam int SEL_W   = 8;
   localparam int VER_W   = 4;
   localparam int MSG_W   = 4;

   // word addresses
   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_MATCH = 3'd1;
   localparam logic [ADDR_W-1:0] A_PORT  = 3'd2;
   localparam logic [ADDR_W-1:0] A_TS_LO = 3'd3;
   localparam logic [ADDR_W-1:0] A_TS_HI = 3'd4;

   // filter mode field (control bits 3:1)
   localparam logic [2:0] MODE_L2_V2  = 3'd0;
   localparam logic [2:0] MODE_L4_V1  = 3'd1;
   localparam logic [2:0] MODE_V2_ANY = 3'd2;
   localparam logic [2:0] MODE_ALL    = 3'd4;
   localparam logic [2:0] MODE_V2_EVT = 3'd5;

   localparam logic [VER_W-1:0] VER_ONE = 4'd1;
   localparam logic [VER_W-1:0] VER_TWO = 4'd2;
   localparam logic [MSG_W-1:0] MSG_PDLY_REQ  = 4'd2;
   localparam logic [MSG_W-1:0] MSG_PDLY_RESP = 4'd3;

   typedef struct packed {
      logic               en;
      logic [2:0]         mode;
      logic [ETYPE_W-1:0] etype;
      logic [SEL_W-1:0]   v1_sel;
      logic [SEL_W-1:0]   v2_sel;
      logic [PORT_W-1:0]  port_sw;
   } cfg_t;

   typedef struct packed {
      logic [ETYPE_W-1:0] etype;
      logic               is_udp;
      logic [PORT_W-1:0]  dport;
      logic [VER_W-1:0]   ver;
      logic [SEL_W-1:0]   v1_ctl;
      logic [MSG_W-1:0]   v2_msg;
   } hdr_t;

   function automatic logic [PORT_W-1:0] swap_bytes(input logic [PORT_W-1:0] v);
      return {v[7:0], v[15:8]};
   endfunction

endpackage

// File: rtl/ptp_rx_stamp_regs.sv
module ptp_rx_stamp_regs
   import ptp_rx_stamp_pkg::*;
#(
   parameter int TIME_W   = 64,
   parameter bit FREQ_IND = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic [TIME_W-1:0] ts_q,
   input  logic              ts_valid,
   output cfg_t              cfg_q,
   output logic [REG_W-1:0]  reg_rdata
);
   localparam int HALF = TIME_W / 2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            A_CTRL: begin
               cfg_q.en   <= reg_wdata[4];
               cfg_q.mode <= reg_wdata[3:1];
            end
            A_MATCH: begin
               cfg_q.etype  <= reg_wdata[15:0];
               cfg_q.v1_sel <= reg_wdata[23:16];
               cfg_q.v2_sel <= reg_wdata[31:24];
            end
            A_PORT:  cfg_q.port_sw <= reg_wdata[PORT_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: begin
            reg_rdata[0]   = ts_valid;
            reg_rdata[3:1] = cfg_q.mode;
            reg_rdata[4]   = cfg_q.en;
            reg_rdata[5]   = FREQ_IND;
         end
         A_MATCH: reg_rdata = {cfg_q.v2_sel, cfg_q.v1_sel, cfg_q.etype};
         A_PORT:  reg_rdata[PORT_W-1:0] = cfg_q.port_sw;
         A_TS_LO: reg_rdata = ts_q[HALF-1:0];
         A_TS_HI: reg_rdata = ts_q[TIME_W-1:HALF];
         default: reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ptp_rx_stamp_class.sv
module ptp_rx_stamp_class
   import ptp_rx_stamp_pkg::*;
(
   input  cfg_t cfg,
   input  hdr_t hdr,
   output logic hit
);
   logic l2_hit, l4_hit, is_v1, is_v2, v1_pick, v2_pick, v2_event;

   always_comb begin
      l2_hit   = !hdr.is_udp && (hdr.etype == cfg.etype);
      l4_hit   = hdr.is_udp && (cfg.port_sw != '0) &&
                 (hdr.dport == swap_bytes(cfg.port_sw));
      is_v1    = (hdr.ver == VER_ONE);
      is_v2    = (hdr.ver == VER_TWO);
      v1_pick  = is_v1 && (hdr.v1_ctl == cfg.v1_sel);
      v2_pick  = is_v2 && (({{(SEL_W-MSG_W){1'b0}}, hdr.v2_msg} == cfg.v2_sel) ||
                           (hdr.v2_msg == MSG_PDLY_REQ) ||
                           (hdr.v2_msg == MSG_PDLY_RESP));
      v2_event = is_v2 && (hdr.v2_msg[MSG_W-1:2] == '0);
      case (cfg.mode)
         MODE_L2_V2:  hit = l2_hit && v2_pick;
         MODE_L4_V1:  hit = l4_hit && v1_pick;
         MODE_V2_ANY: hit = (l2_hit || l4_hit) && v2_pick;
         MODE_ALL:    hit = 1'b1;
         MODE_V2_EVT: hit = (l2_hit || l4_hit) && v2_event;
         default:     hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/ptp_rx_stamp_capture.sv
module ptp_rx_stamp_capture #(
   parameter int TIME_W  = 64,
   parameter int SOF_LAT = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] sys_time,
   input  logic              sof,
   input  logic              take,
   input  logic              clr,
   output logic [TIME_W-1:0] ts_q,
   output logic              ts_valid
);
   logic              sof_tap;
   logic [TIME_W-1:0] snap_q;

   generate
      if (SOF_LAT == 0) begin : g_direct
         assign sof_tap = sof;
      end else begin : g_delay
         logic [SOF_LAT-1:0] sof_sr;
         for (genvar i = 0; i < SOF_LAT; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk) begin
                  if (!rst_n) sof_sr[i] <= 1'b0;
                  else        sof_sr[i] <= sof;
               end
            end else begin : g_next
               always_ff @(posedge clk) begin
                  if (!rst_n) sof_sr[i] <= 1'b0;
                  else        sof_sr[i] <= sof_sr[i-1];
               end
            end
         end
         assign sof_tap = sof_sr[SOF_LAT-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q   <= '0;
         ts_q     <= '0;
         ts_valid <= 1'b0;
      end else begin
         if (sof_tap) snap_q <= sys_time;
         if (!ts_valid && take) begin
            ts_valid <= 1'b1;
            ts_q     <= snap_q;
         end else if (clr) begin
            ts_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ptp_rx_stamp.sv
module ptp_rx_stamp
   import ptp_rx_stamp_pkg::*;
#(
   parameter int TIME_W   = 64,
   parameter int SOF_LAT  = 2,
   parameter bit FREQ_IND = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] sys_time,
   input  logic              sof,
   input  logic              hdr_valid,
   input  logic [15:0]       hdr_etype,
   input  logic              hdr_is_udp,
   input  logic [15:0]       hdr_udp_dport,
   input  logic [3:0]        hdr_ptp_ver,
   input  logic [7:0]        hdr_v1_ctrl,
   input  logic [3:0]        hdr_v2_msg,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              ts_valid
);
   generate
      if (TIME_W != 2 * REG_W) begin : g_bad_width
         $error("TIME_W must be twice the register width");
      end
      if (SOF_LAT < 0) begin : g_bad_lat
         $error("SOF_LAT must not be negative");
      end
   endgenerate

   cfg_t              cfg_q;
   hdr_t              hdr;
   logic              hit;
   logic              hi_read;
   logic              cfg_en;
   logic [2:0]        cfg_mode;
   logic [TIME_W-1:0] ts_q;

   assign hdr      = '{etype: hdr_etype, is_udp: hdr_is_udp, dport: hdr_udp_dport,
                       ver: hdr_ptp_ver, v1_ctl: hdr_v1_ctrl, v2_msg: hdr_v2_msg};
   assign hi_read  = reg_rd && (reg_addr == A_TS_HI);
   assign cfg_en   = cfg_q.en;
   assign cfg_mode = cfg_q.mode;

   ptp_rx_stamp_regs #(.TIME_W(TIME_W), .FREQ_IND(FREQ_IND)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .ts_q(ts_q), .ts_valid(ts_valid),
      .cfg_q(cfg_q), .reg_rdata(reg_rdata)
   );

   ptp_rx_stamp_class u_class (
      .cfg(cfg_q), .hdr(hdr), .hit(hit)
   );

   ptp_rx_stamp_capture #(.TIME_W(TIME_W), .SOF_LAT(SOF_LAT)) u_cap (
      .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .sof(sof),
      .take(hdr_valid && hit && cfg_en), .clr(hi_read),
      .ts_q(ts_q), .ts_valid(ts_valid)
   );

endmodule

// File: rtl/ptp_rx_stamp_chk.sv
module ptp_rx_stamp_chk #(
   parameter int TIME_W = 64
)(
   input logic              clk,
   input logic              rst_n,
   input logic              hdr_valid,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [2:0]        reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              ts_valid,
   input logic              cfg_en,
   input logic [2:0]        cfg_mode,
   input logic [TIME_W-1:0] ts_q
);
   logic hi_rd;
   assign hi_rd = reg_rd && (reg_addr == 3'd4);

   AST_HOLD_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid && !hi_rd |=> ts_valid && $stable(ts_q)); // R11
   AST_HI_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid && hi_rd |=> !ts_valid); // R12
   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en && !ts_valid |=> !ts_valid); // R10
   AST_CAPTURE_ON_HDR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ts_valid) |-> $past(hdr_valid)); // R3
   AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_addr == 3'd0 |=> cfg_mode == $past(reg_wdata[3:1])); // R2
   AST_UNDEF_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 3'd3 || cfg_mode == 3'd6 || cfg_mode == 3'd7) && !ts_valid
      |=> !ts_valid); // R9
endmodule

bind ptp_rx_stamp ptp_rx_stamp_chk #(.TIME_W(TIME_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .reg_wr(reg_wr),
   .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .ts_valid(ts_valid), .cfg_en(cfg_en), .cfg_mode(cfg_mode), .ts_q(ts_q)
);

// File: tb/ptp_rx_stamp_bench.sv
module ptp_rx_stamp_bench;
   localparam int LAT  = 2;
   localparam bit FREQ = 1'b1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] systime = 64'h0000_0001_0000_0000;
   logic        sof = 1'b0, hdr_valid = 1'b0, hdr_is_udp = 1'b0;
   logic [15:0] hdr_etype = '0, hdr_udp_dport = '0;
   logic [3:0]  hdr_ptp_ver = '0, hdr_v2_msg = '0;
   logic [7:0]  hdr_v1_ctrl = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        ts_valid;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) systime <= systime + 64'd8;

   ptp_rx_stamp #(.TIME_W(64), .SOF_LAT(LAT), .FREQ_IND(FREQ)) u_ptp_rx_stamp (
      .clk(clk), .rst_n(rst_n), .sys_time(systime), .sof(sof),
      .hdr_valid(hdr_valid), .hdr_etype(hdr_etype), .hdr_is_udp(hdr_is_udp),
      .hdr_udp_dport(hdr_udp_dport), .hdr_ptp_ver(hdr_ptp_ver),
      .hdr_v1_ctrl(hdr_v1_ctrl), .hdr_v2_msg(hdr_v2_msg),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ts_valid(ts_valid)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic frame(input bit udp, input logic [15:0] et, input logic [15:0] dp,
                        input logic [3:0] ver, input logic [7:0] ctl,
                        input logic [3:0] msg, output logic [63:0] stamp);
      @(negedge clk); sof = 1'b1; stamp = systime + 64'd8 * LAT;
      @(negedge clk); sof = 1'b0;
      repeat (LAT) @(negedge clk);
      hdr_valid = 1'b1; hdr_is_udp = udp; hdr_etype = et; hdr_udp_dport = dp;
      hdr_ptp_ver = ver; hdr_v1_ctrl = ctl; hdr_v2_msg = msg;
      @(negedge clk); hdr_valid = 1'b0;
   endtask

   function automatic bit model(input bit en, input logic [2:0] mode,
                                input logic [31:0] mtch, input logic [15:0] port,
                                input bit udp, input logic [15:0] et, input logic [15:0] dp,
                                input logic [3:0] ver, input logic [7:0] ctl,
                                input logic [3:0] msg);
      bit via_l2, via_l4, v2ok, v1ok, evt;
      via_l2 = !udp && et == mtch[15:0];
      via_l4 = udp && port != 16'd0 && dp == {port[7:0], port[15:8]};
      v2ok   = ver == 4'd2 && (msg == 4'd2 || msg == 4'd3 || {4'd0, msg} == mtch[31:24]);
      v1ok   = ver == 4'd1 && ctl == mtch[23:16];
      evt    = ver == 4'd2 && msg < 4'd4;
      if (!en) return 1'b0;
      case (mode)
         3'd0: return via_l2 && v2ok;
         3'd1: return via_l4 && v1ok;
         3'd2: return (via_l2 || via_l4) && v2ok;
         3'd4: return 1'b1;
         3'd5: return (via_l2 || via_l4) && evt;
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, lo, hi;
      logic [63:0] s1, s2;
      string tag;
      void'($urandom(32'd7321));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      peek(3'd0, d); chk("R1 ctrl", d, {26'd0, FREQ, 5'd0});
      peek(3'd1, d); chk("R1 match", d, 0);
      peek(3'd2, d); chk("R1 port", d, 0);
      chk("R1 valid", ts_valid, 0);

      // R2 readback, read-only bits ignored
      wr(3'd0, 32'hFFFF_FFFF); peek(3'd0, d); chk("R2 ctrl", d, {26'd0, FREQ, 5'b11110});
      wr(3'd1, 32'h0100_88F7); peek(3'd1, d); chk("R2 match", d, 32'h0100_88F7);
      wr(3'd2, 32'h0000_3F01); peek(3'd2, d); chk("R2 port", d, 32'h3F01);

      // R3 / R11 / R12: all-frames mode, hold first stamp
      wr(3'd0, 32'h18);
      frame(1'b0, 16'h1234, 0, 4'd0, 0, 0, s1);
      #1 chk("R3 valid", ts_valid, 1);
      frame(1'b0, 16'h1234, 0, 4'd0, 0, 0, s2);
      rd(3'd3, lo); chk("R3 low", lo, s1[31:0]);
      peek(3'd0, d); chk("R12 low read keeps valid", d[0], 1);
      rd(3'd4, hi); chk("R11 high held", hi, s1[63:32]);
      chk("R11 low held", lo != s2[31:0], 1);
      peek(3'd0, d); chk("R12 high read clears", d[0], 0);

      // R5 port register zero
      wr(3'd0, 32'h12); wr(3'd1, 32'h0000_88F7); wr(3'd2, 0);
      frame(1'b1, 16'h0800, 16'd0, 4'd1, 0, 0, s1);
      peek(3'd0, d); chk("R5 zero port", d[0], 0);
      // R5 byte order: port 319 with swapped register
      wr(3'd2, 32'h3F01);
      frame(1'b1, 16'h0800, 16'h3F01, 4'd1, 0, 0, s1);
      peek(3'd0, d); chk("R5 unswapped port rejected", d[0], 0);
      frame(1'b1, 16'h0800, 16'd319, 4'd1, 0, 0, s1);
      peek(3'd0, d); chk("R5 port 319", d[0], 1);
      rd(3'd3, lo); chk("R5 stamp", lo, s1[31:0]);
      rd(3'd4, hi);

      // R4 peer-delay response accepted in v2 L2 mode
      wr(3'd0, 32'h10);
      frame(1'b0, 16'h88F7, 0, 4'd2, 0, 4'd3, s1);
      peek(3'd0, d); chk("R4 pdelay resp", d[0], 1);
      rd(3'd4, hi); chk("R4 stamp hi", hi, s1[63:32]);

      // R10 enable off, R9 undefined code
      wr(3'd0, 32'h08);
      frame(1'b0, 16'h88F7, 0, 4'd2, 0, 0, s1);
      peek(3'd0, d); chk("R10 disabled", d[0], 0);
      wr(3'd0, 32'h16);
      frame(1'b0, 16'h88F7, 0, 4'd2, 0, 0, s1);
      peek(3'd0, d); chk("R9 undefined mode", d[0], 0);

      // constrained random
      for (int it = 0; it < 400; it++) begin
         bit en, udp, exp;
         logic [2:0] mode;
         logic [31:0] mtch;
         logic [15:0] port, et, dp;
         logic [3:0] ver, msg;
         logic [7:0] ctl;
         en   = ($urandom_range(9) != 0);
         mode = 3'($urandom_range(7));
         mtch = {8'($urandom_range(1)), 8'($urandom_range(1)), 16'h88F7};
         port = ($urandom_range(3) == 0) ? 16'd0 : 16'h3F01;
         udp  = 1'($urandom_range(1));
         et   = udp ? 16'h0800 : (($urandom_range(3) == 0) ? 16'($urandom) : 16'h88F7);
         dp   = !udp ? 16'd0 : (($urandom_range(3) == 0) ? 16'($urandom) : 16'd319);
         ver  = ($urandom_range(4) == 0) ? 4'($urandom) : (($urandom_range(1) == 1) ? 4'd1 : 4'd2);
         msg  = ($urandom_range(1) == 1) ? 4'($urandom_range(3)) : 4'($urandom);
         ctl  = 8'($urandom_range(3));
         wr(3'd0, {27'd0, en, mode, 1'b0});
         wr(3'd1, mtch);
         wr(3'd2, {16'd0, port});
         frame(udp, et, dp, ver, ctl, msg, s1);
         exp = model(en, mode, mtch, port, udp, et, dp, ver, ctl, msg);
         case (mode)
            3'd0: tag = "R4 random";
            3'd1: tag = "R5 random";
            3'd2: tag = "R6 random";
            3'd4: tag = "R7 random";
            3'd5: tag = "R8 random";
            default: tag = "R9 random";
         endcase
         if (!en) tag = "R10 random";
         peek(3'd0, d); chk(tag, d[0], exp);
         if (exp) begin
            rd(3'd3, lo); chk("R3 random low", lo, s1[31:0]);
         end
         rd(3'd4, hi);
         if (exp) chk("R3 random high", hi, s1[63:32]);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule